// File: doc/BRIEF.md
# Test-Mode Opcode Stream Driver

This block drives a target processor that is held in a special test mode. In that mode the processor fetches every opcode and operand from an 8-bit bus, one byte per internal cycle. The driver generates the clock for the target by dividing the system clock. It also drives the active-high reset and the active-low test-mode input of the target. After a start pulse it releases reset and presents a fixed byte program on the bus. The target divides the supplied clock by two, so the driver holds each byte for two supplied clock periods.

The program has two parts. The first is an alignment preamble: a run of one-byte no-op opcodes, then a short sequence that reads as a three-, two- or one-byte instruction depending on where the target's fetch lands, then one filler byte. Because of this, the payload always starts on an instruction boundary. The payload stores 0x55 to the target's output port and then halts the target. The driver waits a programmable number of target cycles and samples the port. It then holds a pass/fail verdict and a done flag until the next start.

Top module: `tmsd_driver`

## Requirements
- R1: After system reset, the outputs are as follows: `tgt_reset_o`=1, `tgt_test_n_o`=1, `tgt_bus_o`=0xFF, `tgt_clk_o`=0, `done_o`=0, `pass_o`=0.
- R2: `tgt_clk_o` is a square wave with a period of 2*HALF_DIV system cycles, high for HALF_DIV cycles of each period.
- R3: After a start pulse, `tgt_reset_o` is 1 and `tgt_test_n_o` is 0 for RST_CYC target CPU cycles, one CPU cycle being two `tgt_clk_o` periods. Because the first CPU cycle may be partial, `tgt_clk_o` has between 2*RST_CYC-2 and 2*RST_CYC rising edges in that time. Reset is released only at a CPU-cycle boundary.
- R4: After reset is released, with `tgt_reset_o`=0 and `tgt_test_n_o`=0, the 21-byte program appears on `tgt_bus_o` in order. Each byte is stable over exactly two rising edges of `tgt_clk_o`, and the bus changes only while `tgt_clk_o` falls.
- R5: The program consists of the following bytes. Bytes 0 to 9 are 0xEA. Bytes 10 to 12 are 0x2C, 0x24, 0xEA. Byte 13 is a filler byte. Bytes 14 to 20 are 0x78, 0xA9, 0x55, 0x85, 0x83, a filler byte, 0x02. Filler bytes are driven as 0xFF.
- R6: After the last program byte, the bus keeps showing 0x02 until the next start.
- R7: The port input is sampled SETTLE_CYC CPU cycles after the last program byte, which is 2*SETTLE_CYC further rising edges of `tgt_clk_o`. At that moment `done_o` rises, and `pass_o` is 1 exactly when the sampled value equals EXPECT (0x55).
- R8: Once `done_o` is 1, `done_o` and `pass_o` keep their values until the next start, whatever the port input does.
- R9: A start pulse in any state restarts the sequence. In the cycle after the pulse, `tgt_reset_o` is 1 and `done_o` and `pass_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| port_d_i | input | 8 | Target output port being checked |
| tgt_clk_o | output | 1 | Divided clock supplied to the target |
| tgt_reset_o | output | 1 | Target reset, active high |
| tgt_test_n_o | output | 1 | Target test-mode select, active low |
| tgt_bus_o | output | 8 | Byte stream fed to the target |
| done_o | output | 1 | Result is valid |
| pass_o | output | 1 | Sampled port matched the expected value |

## Verification
The assertions assume the following about the inputs:
- `start_i` is a pulse synchronous to `clk`.
- `port_d_i` holds still around the sampling edge.
- Every count parameter is at least one.

The bench drives each start pulse for exactly one cycle, 1 ns after a falling edge. It sets the port value before the run begins and changes it only after `done_o` has risen, to test that the verdict holds. It also gives one start pulse in the middle of a stream, which is the only case where a start arrives outside the idle or done states.

// File: rtl/tmsd_pkg.sv
package tmsd_pkg;

    localparam int PROG_LEN = 21;
    localparam int IDX_W    = $clog2(PROG_LEN);

    localparam logic [7:0] BYTE_FILL = 8'hFF;
    localparam logic [7:0] BYTE_HALT = 8'h02;
    localparam logic [7:0] BYTE_NOP  = 8'hEA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD_RST,
        ST_STREAM,
        ST_SETTLE,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic       reset;
        logic       test_n;
        logic [7:0] bus;
    } tgt_drive_t;

    // Byte program: alignment preamble followed by the store-and-halt payload.
    function automatic logic [7:0] prog_byte(input logic [IDX_W-1:0] idx);
        logic [7:0] b;
        if (idx < IDX_W'(10)) begin
            b = BYTE_NOP;
        end else begin
            case (idx)
                IDX_W'(10): b = 8'h2C;
                IDX_W'(11): b = 8'h24;
                IDX_W'(12): b = BYTE_NOP;
                IDX_W'(14): b = 8'h78;
                IDX_W'(15): b = 8'hA9;
                IDX_W'(16): b = 8'h55;
                IDX_W'(17): b = 8'h85;
                IDX_W'(18): b = 8'h83;
                IDX_W'(20): b = BYTE_HALT;
                default:    b = BYTE_FILL;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/tmsd_clkgen.sv
module tmsd_clkgen #(
    parameter int HALF_DIV = 400
) (
    input  logic clk,
    input  logic rst,
    output logic tgt_clk_o,
    output logic cpu_edge_o
);
    localparam int DW = $clog2(HALF_DIV + 1);

    logic [DW-1:0] div_cnt;
    logic [1:0]    quarter;
    logic          tick;

    assign tick       = (div_cnt == DW'(HALF_DIV - 1));
    assign tgt_clk_o  = quarter[0];
    assign cpu_edge_o = tick && (quarter == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            quarter <= 2'd0;
        end else if (tick) begin
            div_cnt <= '0;
            quarter <= quarter + 2'd1;
        end else begin
            div_cnt <= div_cnt + DW'(1);
        end
    end

    p_div_range_r2: assert property (@(posedge clk) disable iff (rst)
        div_cnt <= DW'(HALF_DIV - 1));

    // A CPU-cycle boundary always coincides with a falling target clock (R2/R4).
    p_edge_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_edge_o |=> !tgt_clk_o);

endmodule

// File: rtl/tmsd_seq.sv
module tmsd_seq
    import tmsd_pkg::*;
#(
    parameter int         RST_CYC    = 4,
    parameter int         SETTLE_CYC = 8,
    parameter logic [7:0] EXPECT     = 8'h55
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       cpu_edge_i,
    input  logic [7:0] port_d_i,
    output logic       tgt_reset_o,
    output logic       tgt_test_n_o,
    output logic [7:0] tgt_bus_o,
    output logic       done_o,
    output logic       pass_o
);
    localparam int CNT_MAX = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_state_t     state;
    logic [IDX_W-1:0] idx;
    logic [CW-1:0]    cnt;
    tgt_drive_t       drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            cnt    <= '0;
            done_o <= 1'b0;
            pass_o <= 1'b0;
        end else if (start_i) begin
            state  <= ST_HOLD_RST;
            idx    <= '0;
            cnt    <= '0;
            done_o <= 1'b0;
            pass_o <= 1'b0;
        end else if (cpu_edge_i) begin
            case (state)
                ST_HOLD_RST: begin
                    if (cnt == CW'(RST_CYC - 1)) begin
                        state <= ST_STREAM;
                        cnt   <= '0;
                        idx   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_STREAM: begin
                    if (idx == IDX_W'(PROG_LEN - 1)) begin
                        state <= ST_SETTLE;
                        cnt   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_SETTLE: begin
                    if (cnt == CW'(SETTLE_CYC - 1)) begin
                        state  <= ST_DONE;
                        done_o <= 1'b1;
                        pass_o <= (port_d_i == EXPECT);
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        drv = '{reset: 1'b0, test_n: 1'b0, bus: BYTE_HALT};
        case (state)
            ST_IDLE:     drv = '{reset: 1'b1, test_n: 1'b1, bus: BYTE_FILL};
            ST_HOLD_RST: drv = '{reset: 1'b1, test_n: 1'b0, bus: BYTE_FILL};
            ST_STREAM:   drv.bus = prog_byte(idx);
            default:     ;
        endcase
    end

    assign tgt_reset_o  = drv.reset;
    assign tgt_test_n_o = drv.test_n;
    assign tgt_bus_o    = drv.bus;

    p_idx_bound_r4: assert property (@(posedge clk) disable iff (rst)
        idx < IDX_W'(PROG_LEN));

    p_bus_steady_r4: assert property (@(posedge clk) disable iff (rst)
        (!cpu_edge_i && !start_i) |=> $stable(tgt_bus_o));

    p_reset_release_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt_reset_o) |-> $past(cpu_edge_i));

    p_verdict_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(pass_o)));

    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!done_o && tgt_reset_o));

endmodule

// File: rtl/tmsd_driver.sv
module tmsd_driver #(
    parameter int         HALF_DIV   = 400,
    parameter int         RST_CYC    = 4,
    parameter int         SETTLE_CYC = 8,
    parameter logic [7:0] EXPECT     = 8'h55
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] port_d_i,
    output logic       tgt_clk_o,
    output logic       tgt_reset_o,
    output logic       tgt_test_n_o,
    output logic [7:0] tgt_bus_o,
    output logic       done_o,
    output logic       pass_o
);
    logic cpu_edge;

    tmsd_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .tgt_clk_o  (tgt_clk_o),
        .cpu_edge_o (cpu_edge)
    );

    tmsd_seq #(
        .RST_CYC    (RST_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .EXPECT     (EXPECT)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .cpu_edge_i   (cpu_edge),
        .port_d_i     (port_d_i),
        .tgt_reset_o  (tgt_reset_o),
        .tgt_test_n_o (tgt_test_n_o),
        .tgt_bus_o    (tgt_bus_o),
        .done_o       (done_o),
        .pass_o       (pass_o)
    );

    // The test-mode input is never released while reset is low (R3/R4).
    p_test_during_run_r4: assert property (@(posedge clk) disable iff (rst)
        !tgt_reset_o |-> !tgt_test_n_o);

endmodule

// File: tb/tmsd_driver_tb.sv
`timescale 1ns/1ps
module tmsd_driver_tb_top;
    localparam int HALF   = 2;
    localparam int RSTC   = 3;
    localparam int SETTLE = 4;
    localparam int LOGN   = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] port_d_i = 8'h00;
    logic       tgt_clk_o, tgt_reset_o, tgt_test_n_o, done_o, pass_o;
    logic [7:0] tgt_bus_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tmsd_driver #(.HALF_DIV(HALF), .RST_CYC(RSTC), .SETTLE_CYC(SETTLE), .EXPECT(8'h55)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .port_d_i(port_d_i),
        .tgt_clk_o(tgt_clk_o), .tgt_reset_o(tgt_reset_o), .tgt_test_n_o(tgt_test_n_o),
        .tgt_bus_o(tgt_bus_o), .done_o(done_o), .pass_o(pass_o)
    );

    // Rising-edge logger of target-side signals, sampled on falling system edges.
    bit         log_en = 0;
    int         log_n = 0;
    logic       prev_clk = 1'b0;
    logic [7:0] lg_bus [LOGN];
    logic       lg_rst [LOGN];
    logic       lg_tst [LOGN];
    logic       lg_done [LOGN];

    always @(negedge clk) begin
        if (log_en && tgt_clk_o && !prev_clk && log_n < LOGN) begin
            lg_bus[log_n]  = tgt_bus_o;
            lg_rst[log_n]  = tgt_reset_o;
            lg_tst[log_n]  = tgt_test_n_o;
            lg_done[log_n] = done_o;
            log_n = log_n + 1;
        end
        prev_clk = tgt_clk_o;
    end

    function automatic logic [7:0] exp_byte(input int i);
        logic [7:0] seq [21];
        seq = '{8'hEA, 8'hEA, 8'hEA, 8'hEA, 8'hEA, 8'hEA, 8'hEA, 8'hEA, 8'hEA, 8'hEA,
                8'h2C, 8'h24, 8'hEA, 8'hFF,
                8'h78, 8'hA9, 8'h55, 8'h85, 8'h83, 8'hFF, 8'h02};
        return seq[i];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); #1;
        start_i = 1'b1;
        log_n = 0;
        log_en = 1;
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000 && !done_o; i++) @(negedge clk);
        chk(done_o == 1'b1, "R7 done reached", done_o, 1);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(tgt_reset_o == 1'b1, "R1 tgt_reset", tgt_reset_o, 1);
        chk(tgt_test_n_o == 1'b1, "R1 tgt_test_n", tgt_test_n_o, 1);
        chk(tgt_bus_o == 8'hFF, "R1 bus", tgt_bus_o, 8'hFF);
        chk(tgt_clk_o == 1'b0, "R1 tgt_clk", tgt_clk_o, 0);
        chk(done_o == 1'b0 && pass_o == 1'b0, "R1 done/pass", {done_o, pass_o}, 0);
    endtask

    task automatic t_clock();
        int per = 0;
        int hi = 0;
        while (!(tgt_clk_o && !prev_clk)) @(negedge clk);
        @(negedge clk);
        per = 1;
        hi = tgt_clk_o ? 2 : 1;
        while (!(tgt_clk_o && !prev_clk)) begin
            @(negedge clk);
            per++;
            if (tgt_clk_o) hi++;
        end
        hi--; // the final sample is the next rising edge
        chk(per == 2 * HALF, "R2 period", per, 2 * HALF);
        chk(hi == HALF, "R2 high time", hi, HALF);
    endtask

    task automatic t_run(input logic [7:0] portval, input bit exp_pass);
        int k = 0;
        int nrst = 0;
        bit seq_ok = 1;
        int bad_at = -1;
        port_d_i = portval;
        pulse_start();
        wait_done();
        log_en = 0;
        while (k < log_n && lg_rst[k]) begin
            if (lg_tst[k]) seq_ok = 0;
            nrst++;
            k++;
        end
        chk(nrst >= 2 * RSTC - 2 && nrst <= 2 * RSTC, "R3 reset hold edges", nrst, 2 * RSTC);
        chk(seq_ok, "R3 test strobe low in reset", 0, 0);
        for (int j = 0; j < 42; j++) begin
            if (k + j >= log_n || lg_bus[k + j] != exp_byte(j / 2) ||
                lg_rst[k + j] || lg_tst[k + j]) begin
                if (bad_at < 0) bad_at = j;
            end
        end
        chk(bad_at < 0, "R4 R5 program bytes", bad_at,
            (bad_at >= 0 && k + bad_at < log_n) ? exp_byte(bad_at / 2) : 0);
        if (bad_at >= 0 && k + bad_at < log_n)
            $display("  at edge %0d bus=%0h", bad_at, lg_bus[k + bad_at]);
        seq_ok = 1;
        for (int j = 42; j < log_n - k; j++)
            if (lg_bus[k + j] != 8'h02 || lg_done[k + j]) seq_ok = 0;
        chk(seq_ok, "R6 halt byte repeats", 0, 0);
        chk(log_n - k == 42 + 2 * SETTLE, "R7 settle edges", log_n - k, 42 + 2 * SETTLE);
        chk(pass_o == exp_pass, "R7 verdict", pass_o, exp_pass);
        // R8: flip the port after done; verdict and flag must hold.
        port_d_i = ~portval;
        repeat (40) @(negedge clk);
        chk(done_o == 1'b1 && pass_o == exp_pass, "R8 verdict held", {done_o, pass_o}, {1'b1, exp_pass});
        chk(tgt_bus_o == 8'h02, "R6 bus after done", tgt_bus_o, 8'h02);
    endtask

    task automatic t_restart();
        port_d_i = 8'h55;
        pulse_start();
        repeat (60) @(negedge clk);
        chk(tgt_reset_o == 1'b0, "R9 mid-stream before restart", tgt_reset_o, 0);
        @(negedge clk); #1;
        start_i = 1'b1;
        @(negedge clk);
        chk(tgt_reset_o == 1'b1 && done_o == 1'b0 && pass_o == 1'b0,
            "R9 restart", {tgt_reset_o, done_o, pass_o}, 3'b100);
        #1 start_i = 1'b0;
        wait_done();
        chk(pass_o == 1'b1, "R9 pass after restart", pass_o, 1);
        // Start from done state clears the verdict.
        pulse_start();
        chk(done_o == 1'b0 && pass_o == 1'b0, "R9 start clears verdict", {done_o, pass_o}, 0);
        wait_done();
        log_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        t_reset_state();
        t_clock();
        t_run(8'h55, 1'b1);
        t_run(8'h54, 1'b0);
        t_run(8'hAA, 1'b0);
        t_restart();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule